// File: doc/BRIEF.md
# PCI-ISA interrupt wire router

This block collects level-sensitive interrupt wires from one PCI bus and from the ISA devices, and folds them onto a vector of global system interrupt (GSI) lines. Sources change state through single-cycle commands. A PCI command names a device and an INTx pin. An ISA command names an IRQ number. A route command rewrites the steering of one of four shared PCI links. Each PCI wire drives two lines. The first is a fixed high GSI picked by a swizzle formula. The second is a shared link, and that link is steered by its route register onto a low GSI.

Shared lines behave as a wire-OR. The block does this with a per-line assertion counter, and a line reads high while its counter is nonzero. A state bit per source wire filters out repeated commands, so the counters never drift. The GSI vector is registered. Three slices of it are also brought out: the lines that reach the master 8259, the lines that reach the slave 8259, and the lines that reach only the IO-APIC.

Top module: `pci_isa_irq_router`

## Requirements
- R1: Each PCI wire, indexed device*4 + pin, and each ISA wire keeps one state bit. A command that asks for the state a wire already has leaves every output and counter unchanged. Two asserts followed by one deassert leave the wire low.
- R2: An asserted PCI wire (device d, pin p) drives GSI ((d*4 + d/8 + p) mod 32) + 16 high.
- R3: An asserted PCI wire also asserts link (d + p) mod 4. While a link's route register holds a nonzero value r (1 to 15), an active link drives GSI r high.
- R4: ISA IRQ n drives GSI n, except that IRQ 0 drives GSI 2 and GSI 0 stays low.
- R5: A GSI line is high exactly while at least one source (a PCI wire on its high GSI, an ISA wire, or an active routed link) drives it. Deasserting one of several sources leaves the line high.
- R6: Rewriting a route while its link is active moves the drive from the old GSI to the new one, with effect at the same clock edge.
- R7: A route value of 0 disables the link, so the link drives no GSI.
- R8: pic_master carries GSI 0 to 7, pic_slave carries GSI 8 to 15, and ioapic_only carries GSI 16 and up. Each is bit-aligned with gsi_level.
- R9: A command changes the outputs at the first rising clock edge that samples it, and not before.
- R10: A synchronous reset clears all wire states, counters and route registers, so every output is 0 after it.
- R11: A PCI command, an ISA command and a route command given in the same cycle all take effect together, including when they target the same GSI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pci_valid | input | 1 | PCI wire command strobe |
| pci_level | input | 1 | 1 asserts, 0 deasserts the PCI wire |
| pci_dev | input | 5 | PCI device number |
| pci_pin | input | 2 | INTx pin, 0 to 3 |
| isa_valid | input | 1 | ISA wire command strobe |
| isa_level | input | 1 | 1 asserts, 0 deasserts the ISA wire |
| isa_irq | input | 4 | ISA IRQ number |
| route_we | input | 1 | Route register write strobe |
| route_link | input | 2 | Link whose route is written |
| route_irq | input | 4 | New route value, 0 disables the link |
| gsi_level | output | 48 | Registered GSI line levels |
| pic_master | output | 8 | GSI 0 to 7 |
| pic_slave | output | 8 | GSI 8 to 15 |
| ioapic_only | output | 32 | GSI 16 to 47 |

## Verification
The risky overlap is a link that changes its count in the same cycle as its route register is rewritten. This can happen together with an ISA command on the old or the new target GSI. The bench drives all three strobes in one cycle, aiming at the same low GSI. It judges the result against a model that recomputes every line from the wire states and the routes, so no counter arithmetic is involved. A long random phase also issues all command kinds at once, and the outputs are compared on every clock.

// File: rtl/pci_isa_irq_router.sv
module pci_isa_irq_router #(
  parameter int N_DEV  = 32,
  parameter int N_PIN  = 4,
  parameter int N_ISA  = 16,
  parameter int N_LINK = 4,
  parameter int N_GSI  = 48,
  parameter int CNT_W  = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pci_valid,
  input  logic                       pci_level,
  input  logic [$clog2(N_DEV)-1:0]   pci_dev,
  input  logic [$clog2(N_PIN)-1:0]   pci_pin,
  input  logic                       isa_valid,
  input  logic                       isa_level,
  input  logic [$clog2(N_ISA)-1:0]   isa_irq,
  input  logic                       route_we,
  input  logic [$clog2(N_LINK)-1:0]  route_link,
  input  logic [$clog2(N_ISA)-1:0]   route_irq,
  output logic [N_GSI-1:0]           gsi_level,
  output logic [7:0]                 pic_master,
  output logic [7:0]                 pic_slave,
  output logic [N_GSI-17:0]          ioapic_only
);
  localparam int DEV_W  = $clog2(N_DEV);
  localparam int PIN_W  = $clog2(N_PIN);
  localparam int IRQ_W  = $clog2(N_ISA);
  localparam int LNK_W  = $clog2(N_LINK);
  localparam int GSI_W  = $clog2(N_GSI);
  localparam int N_WIRE = N_DEV * N_PIN;
  localparam int HS_W   = 5;
  localparam int PIC_N  = 8;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [N_WIRE-1:0] pci_st;
  logic [N_ISA-1:0]  isa_st;
  logic [IRQ_W-1:0]  route_q  [N_LINK];
  logic [IRQ_W-1:0]  route_nx [N_LINK];
  logic [CNT_W-1:0]  lnk_cnt  [N_LINK];
  logic [CNT_W-1:0]  lnk_nx   [N_LINK];
  logic [CNT_W-1:0]  gsi_cnt  [N_GSI];
  logic [CNT_W-1:0]  gsi_nx   [N_GSI];
  logic [N_GSI-1:0]  lvl_nx;
  logic [N_GSI-1:0]  gsi_q;

  wire [DEV_W+PIN_W-1:0] widx = {pci_dev, pci_pin};
  wire pci_up = pci_valid &  pci_level & ~pci_st[widx];
  wire pci_dn = pci_valid & ~pci_level &  pci_st[widx];
  wire isa_up = isa_valid &  isa_level & ~isa_st[isa_irq];
  wire isa_dn = isa_valid & ~isa_level &  isa_st[isa_irq];

  wire [HS_W-1:0]  hsum     = HS_W'({pci_dev, {PIN_W{1'b0}}}) + HS_W'(pci_dev >> 3) + HS_W'(pci_pin);
  wire [GSI_W-1:0] pci_gsi  = GSI_W'(N_ISA) + GSI_W'(hsum);
  wire [LNK_W-1:0] pci_link = LNK_W'(pci_dev) + LNK_W'(pci_pin);
  wire [GSI_W-1:0] isa_gsi  = (isa_irq == '0) ? GSI_W'(2) : GSI_W'(isa_irq);

  always_comb begin
    for (int l = 0; l < N_LINK; l++) begin
      lnk_nx[l] = lnk_cnt[l];
      if (pci_link == LNK_W'(l)) begin
        if (pci_up && lnk_cnt[l] != CMAX) lnk_nx[l] = lnk_cnt[l] + 1'b1;
        if (pci_dn && lnk_cnt[l] != '0)   lnk_nx[l] = lnk_cnt[l] - 1'b1;
      end
      route_nx[l] = (route_we && route_link == LNK_W'(l)) ? route_irq : route_q[l];
    end
  end

  always_comb begin
    int acc;
    int tot;
    for (int g = 0; g < N_GSI; g++) begin
      acc = 0;
      if (pci_up && pci_gsi == GSI_W'(g)) acc = acc + 1;
      if (pci_dn && pci_gsi == GSI_W'(g)) acc = acc - 1;
      if (isa_up && isa_gsi == GSI_W'(g)) acc = acc + 1;
      if (isa_dn && isa_gsi == GSI_W'(g)) acc = acc - 1;
      for (int l = 0; l < N_LINK; l++) begin
        if (lnk_cnt[l] != '0 && route_q[l] != '0 && GSI_W'(route_q[l]) == GSI_W'(g))
          acc = acc - 1;
        if (lnk_nx[l] != '0 && route_nx[l] != '0 && GSI_W'(route_nx[l]) == GSI_W'(g))
          acc = acc + 1;
      end
      tot = int'(gsi_cnt[g]) + acc;
      if (tot < 0)              gsi_nx[g] = '0;
      else if (tot > int'(CMAX)) gsi_nx[g] = CMAX;
      else                      gsi_nx[g] = CNT_W'(tot);
      lvl_nx[g] = (gsi_nx[g] != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pci_st <= '0;
      isa_st <= '0;
      gsi_q  <= '0;
      for (int l = 0; l < N_LINK; l++) begin
        route_q[l] <= '0;
        lnk_cnt[l] <= '0;
      end
      for (int g = 0; g < N_GSI; g++) gsi_cnt[g] <= '0;
    end else begin
      if (pci_valid) pci_st[widx]    <= pci_level;
      if (isa_valid) isa_st[isa_irq] <= isa_level;
      for (int l = 0; l < N_LINK; l++) begin
        route_q[l] <= route_nx[l];
        lnk_cnt[l] <= lnk_nx[l];
      end
      for (int g = 0; g < N_GSI; g++) gsi_cnt[g] <= gsi_nx[g];
      gsi_q <= lvl_nx;
    end
  end

  assign gsi_level   = gsi_q;
  assign pic_master  = gsi_q[PIC_N-1:0];
  assign pic_slave   = gsi_q[2*PIC_N-1:PIC_N];
  assign ioapic_only = gsi_q[N_GSI-1:N_ISA];
endmodule

module router_chk #(
  parameter int N_DEV = 32,
  parameter int N_PIN = 4,
  parameter int N_ISA = 16,
  parameter int N_GSI = 48
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      pci_valid,
  input logic                      pci_level,
  input logic [$clog2(N_DEV)-1:0]  pci_dev,
  input logic [$clog2(N_PIN)-1:0]  pci_pin,
  input logic                      isa_valid,
  input logic                      isa_level,
  input logic [$clog2(N_ISA)-1:0]  isa_irq,
  input logic [N_GSI-1:0]          gsi_level,
  input logic [N_DEV*N_PIN-1:0]    pci_st,
  input logic [N_ISA-1:0]          isa_st
);
  localparam int GSI_W = $clog2(N_GSI);
  logic [GSI_W-1:0] hi_ix, lo_ix;
  assign hi_ix = GSI_W'(((int'(pci_dev) * 4 + int'(pci_dev) / 8 + int'(pci_pin)) % 32) + 16);
  assign lo_ix = (int'(isa_irq) == 0) ? GSI_W'(2) : GSI_W'(isa_irq);

  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> gsi_level == '0); // R10
  AST_PCI_HIGH_GSI: assert property (@(posedge clk) disable iff (rst)
    pci_valid && pci_level |=> gsi_level[$past(hi_ix)]); // R2
  AST_ISA_MAP: assert property (@(posedge clk) disable iff (rst)
    isa_valid && isa_level |=> gsi_level[$past(lo_ix)]); // R4
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (pci_st == '0 && isa_st == '0) |-> gsi_level == '0); // R5
  AST_HIGH_NEEDS_PCI: assert property (@(posedge clk) disable iff (rst)
    (|gsi_level[N_GSI-1:N_ISA]) |-> (|pci_st)); // R8
endmodule

bind pci_isa_irq_router router_chk #(
  .N_DEV(N_DEV), .N_PIN(N_PIN), .N_ISA(N_ISA), .N_GSI(N_GSI)
) u_chk (.*);

// File: tb/sim_pci_isa_irq_router.sv
`timescale 1ns/1ps
module sim_pci_isa_irq_router;
  logic clk = 0;
  logic rst = 1;
  logic pci_valid = 0, pci_level = 0;
  logic [4:0] pci_dev = 0;
  logic [1:0] pci_pin = 0;
  logic isa_valid = 0, isa_level = 0;
  logic [3:0] isa_irq = 0;
  logic route_we = 0;
  logic [1:0] route_link = 0;
  logic [3:0] route_irq = 0;
  logic [47:0] gsi_level;
  logic [7:0]  pic_master, pic_slave;
  logic [31:0] ioapic_only;

  always #5 clk = ~clk;

  pci_isa_irq_router u0 (.*);

  int checks = 0, failures = 0;
  bit done = 0, started = 0;
  string tag = "R10";

  bit pst[128];
  bit ist[16];
  int rt[4];

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      foreach (pst[i]) pst[i] = 0;
      foreach (ist[i]) ist[i] = 0;
      foreach (rt[i]) rt[i] = 0;
    end else begin
      if (pci_valid) pst[pci_dev * 4 + pci_pin] = pci_level;
      if (isa_valid) ist[isa_irq] = isa_level;
      if (route_we) rt[route_link] = route_irq;
    end
  end

  function automatic logic [47:0] model_gsi();
    logic [47:0] e = '0;
    bit la[4] = '{default: 0};
    for (int d = 0; d < 32; d++)
      for (int p = 0; p < 4; p++)
        if (pst[d * 4 + p]) begin
          e[((d * 4 + d / 8 + p) % 32) + 16] = 1'b1;
          la[(d + p) % 4] = 1;
        end
    for (int i = 0; i < 16; i++)
      if (ist[i]) e[(i == 0) ? 2 : i] = 1'b1;
    for (int l = 0; l < 4; l++)
      if (la[l] && rt[l] != 0) e[rt[l]] = 1'b1;
    return e;
  endfunction

  // R8 slices and R9 timing are judged on every clock against the model
  always @(negedge clk) begin
    if (started) begin
      logic [47:0] e;
      e = model_gsi();
      checks++;
      if (gsi_level !== e || pic_master !== e[7:0] || pic_slave !== e[15:8] ||
          ioapic_only !== e[47:16]) begin
        failures++;
        $display("FAIL %s cycle compare: gsi=%h master=%h slave=%h io=%h expected gsi=%h",
                 tag, gsi_level, pic_master, pic_slave, ioapic_only, e);
      end
    end
  end

  task automatic drive(bit pv, bit pl, int pd, int pp, bit iv, bit il, int ii,
                       bit rw, int rl, int ri);
    @(negedge clk);
    pci_valid = pv; pci_level = pl; pci_dev = 5'(pd); pci_pin = 2'(pp);
    isa_valid = iv; isa_level = il; isa_irq = 4'(ii);
    route_we = rw; route_link = 2'(rl); route_irq = 4'(ri);
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic pci(bit l, int d, int p);
    drive(1, l, d, p, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic isa(bit l, int i);
    drive(0, 0, 0, 0, 1, l, i, 0, 0, 0);
  endtask
  task automatic route(int l, int r);
    drive(0, 0, 0, 0, 0, 0, 0, 1, l, r);
  endtask

  task automatic chk_bit(string t, int idx, bit exp);
    checks++;
    if (gsi_level[idx] !== exp) begin
      failures++;
      $display("FAIL %s gsi[%0d]=%b expected %b", t, idx, gsi_level[idx], exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tag = "R10";
    repeat (3) @(negedge clk);
    checks++;
    if (gsi_level !== '0) begin
      failures++;
      $display("FAIL R10 reset gsi=%h expected 0", gsi_level);
    end
    rst = 0;

    tag = "R9";
    pci(1, 9, 1);                 // high GSI 22, link 2
    chk_bit("R9", 22, 0);         // not yet sampled
    idle();
    chk_bit("R2", 22, 1);
    tag = "R3";
    route(2, 5);
    idle();
    chk_bit("R3", 5, 1);

    tag = "R5";
    pci(1, 0, 2);                 // also link 2, high GSI 18
    pci(0, 9, 1);
    idle();
    chk_bit("R5", 5, 1);
    chk_bit("R5", 22, 0);

    tag = "R6";
    route(2, 10);
    idle();
    chk_bit("R6", 5, 0);
    chk_bit("R6", 10, 1);

    tag = "R7";
    route(2, 0);
    idle();
    chk_bit("R7", 10, 0);

    tag = "R11";
    drive(1, 0, 0, 2, 1, 1, 7, 1, 2, 7);  // link drops, ISA 7 rises, route to 7
    idle();
    chk_bit("R11", 7, 1);
    chk_bit("R11", 18, 0);
    pci(1, 0, 2);
    drive(0, 0, 0, 0, 1, 0, 7, 1, 2, 9);  // ISA 7 drops while link moves 7 -> 9
    idle();
    chk_bit("R11", 7, 0);
    chk_bit("R11", 9, 1);
    pci(0, 0, 2);

    tag = "R1";
    pci(1, 3, 0);                 // GSI 28
    pci(1, 3, 0);
    pci(0, 3, 0);
    idle();
    chk_bit("R1", 28, 0);
    pci(0, 3, 0);
    pci(1, 3, 0);
    idle();
    chk_bit("R1", 28, 1);
    pci(0, 3, 0);

    tag = "R4";
    isa(1, 0);
    idle();
    chk_bit("R4", 2, 1);
    chk_bit("R4", 0, 0);
    isa(0, 0);

    tag = "R8";
    isa(1, 9);
    idle();
    checks++;
    if (pic_slave[1] !== 1'b1) begin
      failures++;
      $display("FAIL R8 pic_slave=%h expected bit1 set", pic_slave);
    end
    isa(0, 9);

    tag = "R10";
    route(1, 12);
    pci(1, 0, 1);                 // link 1 -> GSI 12
    @(negedge clk); rst = 1; pci_valid = 0;
    @(negedge clk); rst = 0;
    pci(1, 0, 1);
    idle();
    chk_bit("R10", 12, 0);
    chk_bit("R10", 17, 1);

    tag = "R5";
    for (int n = 0; n < 3000; n++) begin
      drive(($urandom % 2) == 0, ($urandom % 3) != 0, int'($urandom % 32), int'($urandom % 4),
            ($urandom % 3) == 0, ($urandom % 2) == 0, int'($urandom % 16),
            ($urandom % 5) == 0, int'($urandom % 4), int'($urandom % 16));
    end
    idle();
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule